// File: doc/BRIEF.md
# Programmable Chip-Select Decoder

This block watches the bus cycles of a host with a 20-bit address space and drives the chip-select line of the device that each cycle addresses. There are two memory lines with one end fixed: one anchored at the top of the space and one anchored at address zero. It also drives four memory lines that split one mid-range window into equal blocks, and seven peripheral lines that each cover one 128-byte slot of I/O space. All select lines are active-low. Software programs the size, placement and wait-state count of each region through four configuration registers. The registers are written one at a time over a simple write port.

A bus cycle is framed by a level strobe and tagged as a memory or an I/O cycle. While the strobe is high, the decoder compares the address with every enabled region and asserts at most one select. It also drives a ready line that stays low for the matching region's wait-state count, counted in clocks from the start of the cycle, and then goes high. An address that no enabled region claims gets no select and an immediate ready. Selects and ready are both combinational from the strobe, the cycle type and the address, so a device sees its select in the same clock in which the cycle starts.

Top module: `chip_sel_unit`

## Requirements
- R1: Register index 0 sets up the top region. Bit 0 enables it, bits [3:1] hold a code k, and bits [5:4] hold the wait count. The region covers the last 2^(10+k) bytes, ending at FFFFFh, and drives `hi_sel_n` low.
- R2: Register index 1 sets up the bottom region. Bit 0 enables it, bits [4:1] hold a code k, and bits [6:5] hold the wait count. The region covers 00000h up to 2^(10+k)-1 and drives `lo_sel_n` low. Codes above 8 behave as 8, which gives 256 KB.
- R3: Register index 2 sets up the mid window. Bit 0 enables it, bits [3:1] hold a code k, bits [5:4] hold the wait count, and bits [15:7] hold address bits [19:11] of the window base. Each block is 2^(11+k) bytes; codes 6 and 7 both give 128 KB. Four blocks sit back to back from the base, and block i drives `mid_sel_n[i]` low. Base bits below the 4-block total are ignored.
- R4: Register index 3 sets up the peripheral group. Bit 0 enables it, bits [2:1] hold the wait count, and bits [15:6] hold address bits [19:10] of the base. Slot i covers base+128*i to base+128*i+127 for i = 0..6 and drives `per_sel_n[i]` low. The eighth 128-byte slot selects nothing.
- R5: Memory selects respond only to cycles with `cyc_io` low, and peripheral selects respond only to cycles with `cyc_io` high.
- R6: With `cyc_stb` low, every select is high.
- R7: At most one select is low at a time. Where memory regions overlap, the top region wins over the bottom region, and the bottom region wins over the mid window.
- R8: For a cycle that hits a region with wait count w, `cyc_rdy` is low from the strobe rise until w rising clock edges have passed, then high until the strobe falls. `cyc_rdy` is high whenever the strobe is low.
- R9: A cycle whose address lies in no enabled region, or only in a disabled one, asserts no select and has `cyc_rdy` high at once.
- R10: After reset every region is disabled, every select is high and `cyc_rdy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_idx | input | 2 | Configuration register index |
| cfg_wdata | input | 16 | Configuration write data |
| cyc_stb | input | 1 | Bus cycle active (level) |
| cyc_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| cyc_addr | input | 20 | Cycle address, held while the strobe is high |
| hi_sel_n | output | 1 | Top memory region select, active-low |
| lo_sel_n | output | 1 | Bottom memory region select, active-low |
| mid_sel_n | output | 4 | Mid window block selects, active-low |
| per_sel_n | output | 7 | Peripheral slot selects, active-low |
| cyc_rdy | output | 1 | Cycle ready |

## Verification
Selects respond in the same clock as the strobe and the address, so the bench checks them 1 ns after it drives the inputs, before any rising edge. Ready for a region with w waits is low at that first sample point. It is then checked once after each of the next three rising edges, and at sample n it must equal n >= w. The final sample comes after the strobe is released, where every select must be high and ready high. A configuration write takes effect at the edge that captures it, so each write completes a full clock before the next cycle is driven.

// File: rtl/csu_pkg.sv
package csu_pkg;
  localparam int unsigned ADDR_W      = 20;
  localparam int unsigned CFG_W       = 16;
  localparam int unsigned WS_W        = 2;
  localparam int unsigned LG_W        = 5;
  localparam int unsigned N_MID       = 4;
  localparam int unsigned N_PER       = 7;
  localparam int unsigned MEM_LG_MIN  = 10;
  localparam int unsigned LO_CODE_MAX = 8;
  localparam int unsigned MID_LG_MIN  = 11;
  localparam int unsigned MID_CODE_MAX = 6;
  localparam int unsigned PER_BLK_LG  = 7;
  localparam int unsigned PER_GRP_LG  = PER_BLK_LG + $clog2(N_PER + 1);
  localparam int unsigned PER_BASE_W  = ADDR_W - PER_GRP_LG;
  localparam int unsigned MID_BASE_W  = ADDR_W - MID_LG_MIN;

  typedef enum logic [1:0] {
    REG_HI  = 2'd0,
    REG_LO  = 2'd1,
    REG_MID = 2'd2,
    REG_PER = 2'd3
  } cfg_reg_e;

  typedef struct packed {
    logic            en;
    logic [LG_W-1:0] lg;
    logic [WS_W-1:0] ws;
  } mem_rgn_t;

  typedef struct packed {
    logic              en;
    logic [LG_W-1:0]   lg;
    logic [WS_W-1:0]   ws;
    logic [ADDR_W-1:0] base;
  } mid_rgn_t;

  typedef struct packed {
    logic                  en;
    logic [WS_W-1:0]       ws;
    logic [PER_BASE_W-1:0] base;
  } io_rgn_t;
endpackage

// File: rtl/csu_cfg_regs.sv
module csu_cfg_regs
  import csu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       idx,
  input  logic [CFG_W-1:0] wdata,
  output mem_rgn_t         hi_cfg,
  output mem_rgn_t         lo_cfg,
  output mid_rgn_t         mid_cfg,
  output io_rgn_t          per_cfg
);
  logic [2:0] hi_code, mid_code;
  logic [3:0] lo_code;
  logic [2:0] mid_clamp;
  logic [3:0] lo_clamp;

  assign hi_code   = wdata[3:1];
  assign lo_code   = wdata[4:1];
  assign mid_code  = wdata[3:1];
  assign lo_clamp  = (lo_code > 4'(LO_CODE_MAX)) ? 4'(LO_CODE_MAX) : lo_code;
  assign mid_clamp = (mid_code > 3'(MID_CODE_MAX)) ? 3'(MID_CODE_MAX) : mid_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cfg  <= '0;
      lo_cfg  <= '0;
      mid_cfg <= '0;
      per_cfg <= '0;
    end else if (we) begin
      unique case (cfg_reg_e'(idx))
        REG_HI: begin
          hi_cfg.en <= wdata[0];
          hi_cfg.lg <= LG_W'(MEM_LG_MIN) + LG_W'(hi_code);
          hi_cfg.ws <= wdata[5:4];
        end
        REG_LO: begin
          lo_cfg.en <= wdata[0];
          lo_cfg.lg <= LG_W'(MEM_LG_MIN) + LG_W'(lo_clamp);
          lo_cfg.ws <= wdata[6:5];
        end
        REG_MID: begin
          mid_cfg.en   <= wdata[0];
          mid_cfg.lg   <= LG_W'(MID_LG_MIN) + LG_W'(mid_clamp);
          mid_cfg.ws   <= wdata[5:4];
          mid_cfg.base <= {wdata[CFG_W-1 -: MID_BASE_W], {MID_LG_MIN{1'b0}}};
        end
        REG_PER: begin
          per_cfg.en   <= wdata[0];
          per_cfg.ws   <= wdata[2:1];
          per_cfg.base <= wdata[CFG_W-1 -: PER_BASE_W];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/csu_mem_decode.sv
module csu_mem_decode
  import csu_pkg::*;
#(
  parameter int unsigned NM = N_MID
) (
  input  logic [ADDR_W-1:0] addr,
  input  mem_rgn_t          hi_cfg,
  input  mem_rgn_t          lo_cfg,
  input  mid_rgn_t          mid_cfg,
  output logic              hi_hit,
  output logic              lo_hit,
  output logic [NM-1:0]     mid_hit,
  output logic [WS_W-1:0]   ws
);
  localparam int unsigned IDX_W = $clog2(NM);

  function automatic logic [ADDR_W-1:0] low_mask(input logic [LG_W-1:0] lg);
    return (ADDR_W'(1) << lg) - ADDR_W'(1);
  endfunction

  logic              hi_raw, lo_raw, mid_in;
  logic [LG_W-1:0]   tot_lg;
  logic [IDX_W-1:0]  mid_idx;
  logic [ADDR_W-1:0] mid_shift;
  logic [NM-1:0]     mid_raw;

  assign hi_raw    = hi_cfg.en && (&(addr | low_mask(hi_cfg.lg)));
  assign lo_raw    = lo_cfg.en && ((addr & ~low_mask(lo_cfg.lg)) == '0);
  assign tot_lg    = mid_cfg.lg + LG_W'(IDX_W);
  assign mid_in    = mid_cfg.en && (((addr ^ mid_cfg.base) & ~low_mask(tot_lg)) == '0);
  assign mid_shift = addr >> mid_cfg.lg;
  assign mid_idx   = mid_shift[IDX_W-1:0];

  for (genvar i = 0; i < NM; i++) begin : g_mid
    assign mid_raw[i] = mid_in && (mid_idx == IDX_W'(i));
  end

  // fixed priority: top, then bottom, then mid window
  assign hi_hit  = hi_raw;
  assign lo_hit  = lo_raw && !hi_raw;
  assign mid_hit = (hi_raw || lo_raw) ? '0 : mid_raw;

  always_comb begin
    if (hi_hit)       ws = hi_cfg.ws;
    else if (lo_hit)  ws = lo_cfg.ws;
    else if (|mid_hit) ws = mid_cfg.ws;
    else              ws = '0;
  end
endmodule

// File: rtl/csu_io_decode.sv
module csu_io_decode
  import csu_pkg::*;
#(
  parameter int unsigned NP = N_PER
) (
  input  logic [ADDR_W-1:PER_BLK_LG] addr_hi,
  input  io_rgn_t                    per_cfg,
  output logic [NP-1:0]              per_hit,
  output logic [WS_W-1:0]            ws
);
  localparam int unsigned SLOT_W = PER_GRP_LG - PER_BLK_LG;

  logic              grp_hit;
  logic [SLOT_W-1:0] slot;

  assign grp_hit = per_cfg.en && (addr_hi[ADDR_W-1:PER_GRP_LG] == per_cfg.base);
  assign slot    = addr_hi[PER_GRP_LG-1:PER_BLK_LG];

  for (genvar i = 0; i < NP; i++) begin : g_slot
    assign per_hit[i] = grp_hit && (slot == SLOT_W'(i));
  end

  assign ws = (|per_hit) ? per_cfg.ws : '0;
endmodule

// File: rtl/csu_wait_gen.sv
module csu_wait_gen
  import csu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stb,
  input  logic [WS_W-1:0] ws,
  output logic            rdy
);
  logic            started;
  logic [WS_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0;
      cnt     <= '0;
    end else if (!stb) begin
      started <= 1'b0;
      cnt     <= '0;
    end else if (!started) begin
      started <= 1'b1;
      cnt     <= (ws == '0) ? '0 : ws - WS_W'(1);
    end else if (cnt != '0) begin
      cnt <= cnt - WS_W'(1);
    end
  end

  assign rdy = !stb || (started ? (cnt == '0) : (ws == '0));

  // R8: once ready within a cycle, it stays ready until the strobe drops
  a_r8_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && $past(stb) && $past(rdy)) |-> rdy);
  // R8: a waited region holds ready low in the first clock of the cycle
  a_r8_first_wait: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stb) && ws != '0) |-> !rdy);
endmodule

// File: rtl/chip_sel_unit.sv
module chip_sel_unit
  import csu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_idx,
  input  logic [15:0] cfg_wdata,
  input  logic        cyc_stb,
  input  logic        cyc_io,
  input  logic [19:0] cyc_addr,
  output logic        hi_sel_n,
  output logic        lo_sel_n,
  output logic [3:0]  mid_sel_n,
  output logic [6:0]  per_sel_n,
  output logic        cyc_rdy
);
  mem_rgn_t hi_cfg, lo_cfg;
  mid_rgn_t mid_cfg;
  io_rgn_t  per_cfg;

  logic             hi_hit, lo_hit;
  logic [N_MID-1:0] mid_hit;
  logic [N_PER-1:0] per_hit;
  logic [WS_W-1:0]  mem_ws, io_ws, cyc_ws;
  logic             mem_cyc, io_cyc;

  csu_cfg_regs u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .idx     (cfg_idx),
    .wdata   (cfg_wdata),
    .hi_cfg  (hi_cfg),
    .lo_cfg  (lo_cfg),
    .mid_cfg (mid_cfg),
    .per_cfg (per_cfg)
  );

  csu_mem_decode #(.NM(N_MID)) u_mem (
    .addr    (cyc_addr),
    .hi_cfg  (hi_cfg),
    .lo_cfg  (lo_cfg),
    .mid_cfg (mid_cfg),
    .hi_hit  (hi_hit),
    .lo_hit  (lo_hit),
    .mid_hit (mid_hit),
    .ws      (mem_ws)
  );

  csu_io_decode #(.NP(N_PER)) u_io (
    .addr_hi (cyc_addr[ADDR_W-1:PER_BLK_LG]),
    .per_cfg (per_cfg),
    .per_hit (per_hit),
    .ws      (io_ws)
  );

  assign mem_cyc = cyc_stb && !cyc_io;
  assign io_cyc  = cyc_stb && cyc_io;
  assign cyc_ws  = mem_cyc ? mem_ws : (io_cyc ? io_ws : '0);

  csu_wait_gen u_wait (
    .clk   (clk),
    .rst_n (rst_n),
    .stb   (cyc_stb),
    .ws    (cyc_ws),
    .rdy   (cyc_rdy)
  );

  assign hi_sel_n  = !(mem_cyc && hi_hit);
  assign lo_sel_n  = !(mem_cyc && lo_hit);
  assign mid_sel_n = ~(mid_hit & {N_MID{mem_cyc}});
  assign per_sel_n = ~(per_hit & {N_PER{io_cyc}});

  logic [N_MID+N_PER+1:0] sel_act;
  assign sel_act = ~{per_sel_n, mid_sel_n, lo_sel_n, hi_sel_n};

  // R7: never more than one device selected
  a_r7_single_sel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_act));
  // R6: idle bus selects nothing
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_stb |-> (sel_act == '0));
  // R5: I/O cycles leave memory selects alone
  a_r5_io_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_io |-> (hi_sel_n && lo_sel_n && (&mid_sel_n)));
  // R5: memory cycles leave peripheral selects alone
  a_r5_mem_no_io: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_io |-> (&per_sel_n));
  // R9: a cycle that selects nothing is ready without waits
  a_r9_miss_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_stb && sel_act == '0) |-> cyc_rdy);
  // R8: ready is high whenever no cycle runs
  a_r8_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_stb |-> cyc_rdy);
endmodule

// File: tb/chip_sel_unit_tb_top.sv
module chip_sel_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [15:0] cfg_wdata = '0;
  logic        cyc_stb = 1'b0;
  logic        cyc_io = 1'b0;
  logic [19:0] cyc_addr = '0;
  logic        hi_sel_n, lo_sel_n, cyc_rdy;
  logic [3:0]  mid_sel_n;
  logic [6:0]  per_sel_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  chip_sel_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cyc_stb(cyc_stb), .cyc_io(cyc_io),
    .cyc_addr(cyc_addr), .hi_sel_n(hi_sel_n), .lo_sel_n(lo_sel_n),
    .mid_sel_n(mid_sel_n), .per_sel_n(per_sel_n), .cyc_rdy(cyc_rdy)
  );

  // {io, addr, expected selects {per6..0, mid3..0, lo, hi}, waits}
  localparam int NV = 20;
  localparam logic [35:0] VEC [NV] = '{
    {1'b0, 20'hFFFFF, 13'h0001, 2'd1},  // R1 top end
    {1'b0, 20'hFF000, 13'h0001, 2'd1},  // R1 top start
    {1'b0, 20'hFEFFF, 13'h0000, 2'd0},  // R1 just below
    {1'b0, 20'h00000, 13'h0002, 2'd3},  // R2
    {1'b0, 20'h003FF, 13'h0002, 2'd3},  // R2 last byte
    {1'b0, 20'h00400, 13'h0000, 2'd0},  // R2 just above
    {1'b0, 20'h40000, 13'h0004, 2'd2},  // R3 block 0
    {1'b0, 20'h41FFF, 13'h0008, 2'd2},  // R3 block 1
    {1'b0, 20'h42800, 13'h0010, 2'd2},  // R3 block 2
    {1'b0, 20'h43FFF, 13'h0020, 2'd2},  // R3 block 3
    {1'b0, 20'h44000, 13'h0000, 2'd0},  // R3 past window
    {1'b0, 20'h3FFFF, 13'h0000, 2'd0},  // R3 before window
    {1'b1, 20'h00400, 13'h0040, 2'd1},  // R4 slot 0
    {1'b1, 20'h0047F, 13'h0040, 2'd1},  // R4 slot 0 end
    {1'b1, 20'h00480, 13'h0080, 2'd1},  // R4 slot 1
    {1'b1, 20'h00700, 13'h1000, 2'd1},  // R4 slot 6
    {1'b1, 20'h00780, 13'h0000, 2'd0},  // R4 eighth slot empty
    {1'b1, 20'h00000, 13'h0000, 2'd0},  // R5 io at bottom region
    {1'b0, 20'h00480, 13'h0000, 2'd0},  // R5 mem at peripheral slot
    {1'b1, 20'hFFFFF, 13'h0000, 2'd0}   // R5 io at top region
  };

  function automatic string tag_of(input logic [12:0] s);
    if (s[0])          return "R1";
    if (s[1])          return "R2";
    if (|s[5:2])       return "R3";
    if (|s[12:6])      return "R4";
    return "R9/R5";
  endfunction

  function automatic logic [12:0] sel_now();
    return ~{per_sel_n, mid_sel_n, lo_sel_n, hi_sel_n};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0h exp %0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] idx, input logic [15:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_cycle(input bit io, input logic [19:0] a,
                           input logic [12:0] exp, input int ws, input string req);
    @(negedge clk);
    cyc_io = io; cyc_addr = a; cyc_stb = 1'b1;
    #1;
    check(sel_now() == exp, req, 32'(sel_now()), 32'(exp));
    check(cyc_rdy == (ws == 0), "R8", 32'(cyc_rdy), 32'(ws == 0));
    for (int n = 1; n <= 3; n++) begin
      @(negedge clk); #1;
      check(cyc_rdy == (n >= ws), "R8", 32'(cyc_rdy), 32'(n >= ws));
    end
    @(negedge clk);
    cyc_stb = 1'b0;
    #1;
    check(sel_now() == '0, "R6", 32'(sel_now()), 32'h0);
    check(cyc_rdy == 1'b1, "R8", 32'(cyc_rdy), 32'h1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R10: idle outputs after reset
    check(sel_now() == '0, "R10", 32'(sel_now()), 32'h0);
    check(cyc_rdy == 1'b1, "R10", 32'(cyc_rdy), 32'h1);
    rst_n = 1'b1;
    // R10: regions start disabled
    run_cycle(1'b0, 20'hFFFFF, 13'h0, 0, "R10");
    run_cycle(1'b0, 20'h00000, 13'h0, 0, "R10");
    run_cycle(1'b1, 20'h00400, 13'h0, 0, "R10");

    wr(2'd0, 16'h0015);  // top 4 KB, 1 wait
    wr(2'd1, 16'h0061);  // bottom 1 KB, 3 waits
    wr(2'd2, 16'h4023);  // mid base 40000h, 4 KB blocks, 2 waits
    wr(2'd3, 16'h0043);  // peripherals at 00400h, 1 wait

    for (int v = 0; v < NV; v++) begin
      logic [35:0] e;
      e = VEC[v];
      run_cycle(e[35], e[34:15], e[14:2], int'(e[1:0]), tag_of(e[14:2]));
    end

    // R6: address in a region but strobe low
    @(negedge clk);
    cyc_stb = 1'b0; cyc_io = 1'b0; cyc_addr = 20'hFFFFF;
    #1;
    check(sel_now() == '0, "R6", 32'(sel_now()), 32'h0);
    check(cyc_rdy == 1'b1, "R8", 32'(cyc_rdy), 32'h1);

    // R7 and R2 clamp: bottom code 12 acts as 256 KB, mid window at 0
    wr(2'd1, 16'h0019);
    wr(2'd2, 16'h0023);
    wr(2'd0, 16'h001F);  // top 128 KB
    run_cycle(1'b0, 20'h00000, 13'h0002, 0, "R7");
    run_cycle(1'b0, 20'h03000, 13'h0002, 0, "R7");
    run_cycle(1'b0, 20'h3FFFF, 13'h0002, 0, "R2");
    run_cycle(1'b0, 20'h40000, 13'h0000, 0, "R2");
    run_cycle(1'b0, 20'hE0000, 13'h0001, 1, "R1");
    // R7: top region over the mid window
    wr(2'd2, 16'hE023);
    run_cycle(1'b0, 20'hE0000, 13'h0001, 1, "R7");
    run_cycle(1'b0, 20'hDFFFF, 13'h0000, 0, "R1");
    // R9: disabled peripheral group
    wr(2'd3, 16'h0042);
    run_cycle(1'b1, 20'h00400, 13'h0000, 0, "R9");
    run_cycle(1'b1, 20'h00700, 13'h0000, 0, "R9");

    finish_run();
  end
endmodule